// File: doc/BRIEF.md
# Shared ROM Fetch Arbiter

This block lets two clients share one read port to a program ROM. The first client is a slow host processor. It issues a single-cycle read strobe at most once every several master-clock cycles. The second client is a decompression core that may need one compressed byte in every master cycle. The arbiter gives each host strobe the port at once. It fills the remaining idle slots with sequential reads for the core, and parks their results in a small FIFO. The core drains that FIFO through a show-ahead read port.

Software arms a decompression by pulsing `arm` with a start address. From the next cycle the arbiter streams bytes from that address upward into the FIFO. It does this whether or not the core is reading yet, so the buffer is already full by the time the host's transfer starts pulling output. An `abort` pulse empties the buffer and stops fetching. Re-arming also discards everything queued and restarts at the new address. When no decompression is armed, only host reads reach the ROM.

The ROM is modelled as an asynchronous read. The arbiter registers `rom_rd` and `rom_addr`, and it captures `rom_data` during the cycle in which `rom_rd` is high.

Top module: `rom_fetch_arbiter`

## Requirements
- R1: After reset, `rom_rd`, `host_valid` and `fifo_count` are all zero, and `fifo_empty` is one.
- R2: When `host_req` is high in cycle t, `rom_rd` is high in cycle t+1 with `rom_addr` equal to the `host_addr` of cycle t. This holds even while the core is fetching.
- R3: `host_valid` is high in cycle t+2 for exactly one cycle, with `host_data` equal to the ROM byte at that address. `host_valid` is low in every other cycle.
- R4: While no decompression is armed, every ROM read is one that a host strobe caused.
- R5: Core reads start at the armed start address and rise by one per issued read, modulo 2^ADDR_W. This prefetch runs without any pop from the core.
- R6: `fifo_count` never exceeds DEPTH (8). With no pops, exactly DEPTH core reads are issued and the count settles at DEPTH. Fetching resumes once pops free space.
- R7: The bytes presented on `fifo_data` while `fifo_empty` is low are the ROM contents at consecutive addresses from the start address, in order, with none lost or repeated.
- R8: A `fifo_rd` while the FIFO is empty has no effect; `fifo_count` stays zero.
- R9: An `abort` pulse leaves `fifo_count` zero in the next cycle and stops core reads. A read already in flight is discarded.
- R10: An `arm` while a decompression is active discards the queued bytes. The next byte presented is the ROM byte at the new start address.
- R11: With host strobes every 6 cycles and the core popping whenever data is present, the core receives an unbroken sequential byte stream, and every host read still returns correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst | input | 1 | synchronous active-high reset |
| host_req | input | 1 | single-cycle host read strobe |
| host_addr | input | ADDR_W | host read address |
| host_data | output | DATA_W | byte returned to the host |
| host_valid | output | 1 | host_data valid, one cycle |
| rom_rd | output | 1 | ROM read enable (registered) |
| rom_addr | output | ADDR_W | ROM address (registered) |
| rom_data | input | DATA_W | ROM read data, valid while rom_rd is high |
| arm | input | 1 | pulse: start a decompression fetch stream |
| start_addr | input | ADDR_W | first compressed byte address, sampled with arm |
| abort | input | 1 | pulse: empty FIFO and stop fetching |
| fifo_rd | input | 1 | core pops the head byte |
| fifo_data | output | DATA_W | head byte of the FIFO (show-ahead) |
| fifo_empty | output | 1 | FIFO holds no byte |
| fifo_count | output | CNT_W | bytes held in the FIFO |

## Verification
The checker assumes that `rom_data` settles to the byte at `rom_addr` within the cycle in which `rom_rd` is high. It also assumes that `arm` and `abort` are single pulses, and that `abort` wins when both are high in the same cycle. The bench drives an asynchronous ROM whose contents come from a simple address formula. It drives every control input one time unit after the clock edge, and it pops only when `fifo_count` is non-zero, except in the deliberate empty-pop case. Host strobes are spaced at least six cycles apart during streaming, matching the slow-processor rate on which the throughput claim rests.

// File: rtl/rfa_pkg.sv
package rfa_pkg;
  typedef enum logic {OWN_HOST = 1'b0, OWN_CORE = 1'b1} owner_e;
endpackage

// File: rtl/rfa_fetch_ctl.sv
module rfa_fetch_ctl #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              abort,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              issue,
  output logic              active,
  output logic [ADDR_W-1:0] fetch_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      fetch_addr <= '0;
    end else if (abort) begin
      active <= 1'b0;
    end else if (arm) begin
      active     <= 1'b1;
      fetch_addr <= start_addr;
    end else if (issue) begin
      fetch_addr <= fetch_addr + 1'b1;
    end
  end
endmodule

// File: rtl/rfa_port_mux.sv
module rfa_port_mux
  import rfa_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              core_want,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [DATA_W-1:0] rom_data,
  output logic              core_issue,
  output logic              core_ret,
  output logic              rom_rd,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              host_valid,
  output logic [DATA_W-1:0] host_data
);
  owner_e owner_q;

  // host strobe always takes the slot; core only fills idle ones
  assign core_issue = core_want && !host_req;
  assign core_ret   = rom_rd && (owner_q == OWN_CORE);

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_rd     <= 1'b0;
      rom_addr   <= '0;
      owner_q    <= OWN_HOST;
      host_valid <= 1'b0;
      host_data  <= '0;
    end else begin
      rom_rd     <= host_req || core_issue;
      rom_addr   <= host_req ? host_addr : fetch_addr;
      owner_q    <= host_req ? OWN_HOST : OWN_CORE;
      host_valid <= rom_rd && (owner_q == OWN_HOST);
      if (rom_rd && (owner_q == OWN_HOST)) host_data <= rom_data;
    end
  end
endmodule

// File: rtl/rfa_fifo.sv
module rfa_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  count,
  output logic              empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              pop_ok, push_ok;

  assign empty   = (count == '0);
  assign pop_ok  = pop && !empty;
  assign push_ok = push && ((count != CNT_W'(DEPTH)) || pop_ok);
  assign rdata   = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok && !clear) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      if (push_ok && !pop_ok)      count <= count + 1'b1;
      else if (pop_ok && !push_ok) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/rom_fetch_arbiter.sv
module rom_fetch_arbiter #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic [ADDR_W-1:0] host_addr,
  output logic [DATA_W-1:0] host_data,
  output logic              host_valid,
  output logic              rom_rd,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [DATA_W-1:0] rom_data,
  input  logic              arm,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              abort,
  input  logic              fifo_rd,
  output logic [DATA_W-1:0] fifo_data,
  output logic              fifo_empty,
  output logic [CNT_W-1:0]  fifo_count
);
  logic              active, core_want, core_issue, core_ret, push;
  logic [ADDR_W-1:0] fetch_addr;
  logic [CNT_W:0]    reserved;

  // occupancy plus the one read that may be in flight
  assign reserved  = {1'b0, fifo_count} + (CNT_W+1)'(core_ret);
  assign core_want = active && !arm && !abort && (reserved < (CNT_W+1)'(DEPTH));
  assign push      = core_ret && !arm && !abort;

  rfa_fetch_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst(rst), .arm(arm), .abort(abort), .start_addr(start_addr),
    .issue(core_issue), .active(active), .fetch_addr(fetch_addr)
  );

  rfa_port_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .clk(clk), .rst(rst), .host_req(host_req), .host_addr(host_addr),
    .core_want(core_want), .fetch_addr(fetch_addr), .rom_data(rom_data),
    .core_issue(core_issue), .core_ret(core_ret), .rom_rd(rom_rd),
    .rom_addr(rom_addr), .host_valid(host_valid), .host_data(host_data)
  );

  rfa_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .clear(arm || abort), .push(push), .wdata(rom_data),
    .pop(fifo_rd), .rdata(fifo_data), .count(fifo_count), .empty(fifo_empty)
  );
endmodule

// File: rtl/rfa_checker.sv
module rfa_checker #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              host_req,
  input logic [ADDR_W-1:0] host_addr,
  input logic              rom_rd,
  input logic [ADDR_W-1:0] rom_addr,
  input logic              host_valid,
  input logic              abort,
  input logic              fifo_rd,
  input logic [CNT_W-1:0]  fifo_count,
  input logic              active
);
  p_host_wins_r2: assert property (@(posedge clk) disable iff (rst)
    host_req |=> (rom_rd && rom_addr == $past(host_addr)));

  p_host_return_r3: assert property (@(posedge clk) disable iff (rst)
    host_req |=> ##1 host_valid);

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (rom_rd && !$past(host_req)) |-> $past(active));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= CNT_W'(DEPTH));

  p_empty_pop_r8: assert property (@(posedge clk) disable iff (rst)
    (fifo_count == '0 && fifo_rd) |=> (fifo_count <= CNT_W'(1)));

  p_abort_clears_r9: assert property (@(posedge clk) disable iff (rst)
    abort |=> (fifo_count == '0 && !active));
endmodule

bind rom_fetch_arbiter rfa_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .host_req(host_req), .host_addr(host_addr),
  .rom_rd(rom_rd), .rom_addr(rom_addr), .host_valid(host_valid),
  .abort(abort), .fifo_rd(fifo_rd), .fifo_count(fifo_count), .active(active)
);

// File: tb/rom_fetch_arbiter_test.sv
module rom_fetch_arbiter_test;
  localparam int AW = 16, DW = 8, DEPTH = 8, CW = $clog2(DEPTH + 1);

  logic clk = 0, rst = 1;
  logic host_req = 0, arm = 0, abort = 0, fifo_rd = 0;
  logic [AW-1:0] host_addr = '0, start_addr = '0, rom_addr;
  logic [DW-1:0] host_data, rom_data, fifo_data;
  logic host_valid, rom_rd, fifo_empty;
  logic [CW-1:0] fifo_count;

  int checks = 0, errors = 0, core_reads = 0;
  bit armed = 0, auto_pop = 0, done = 0, hp_v = 0;
  logic [AW-1:0] hp_a = '0, exp_fetch = '0, exp_pop = '0;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] rom_byte(input logic [AW-1:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
  endfunction
  assign rom_data = rom_byte(rom_addr);

  rom_fetch_arbiter uut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    if (host_req) chk(rom_rd && rom_addr == host_addr, "R2 host slot", rom_addr, host_addr);
    else if (rom_rd) begin
      core_reads++;
      chk(armed, "R4 core read while idle", rom_addr, 0);
      chk(rom_addr == exp_fetch, "R5 fetch address", rom_addr, exp_fetch);
      exp_fetch++;
    end
    if (hp_v) chk(host_valid && host_data == rom_byte(hp_a), "R3 host data", host_data, rom_byte(hp_a));
    else chk(!host_valid, "R3 host_valid single", host_valid, 0);
    chk(fifo_count <= DEPTH, "R6 count bound", fifo_count, DEPTH);
    hp_v = host_req; hp_a = host_addr;
    host_req = 0; arm = 0; abort = 0;
    fifo_rd = auto_pop && fifo_count != 0;
    if (fifo_rd) begin
      chk(fifo_data == rom_byte(exp_pop), "R7 stream order", fifo_data, rom_byte(exp_pop));
      exp_pop++;
    end
  endtask

  task automatic do_arm(input logic [AW-1:0] a);
    arm = 1; start_addr = a; armed = 1;
    fifo_rd = 0;
    step_keep();
    exp_fetch = a; exp_pop = a;
  endtask

  // one step without dropping the strobes set just before it
  task automatic step_keep();
    @(posedge clk); #1;
    if (rom_rd) begin
      core_reads++;
      exp_fetch++;
    end
    hp_v = 0; arm = 0; abort = 0; host_req = 0; fifo_rd = 0;
  endtask

  initial begin
    #200000;
    chk(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    chk(!rom_rd && !host_valid && fifo_count == 0 && fifo_empty, "R1 reset state",
        {rom_rd, host_valid, fifo_empty}, 3'b001);

    // R2/R3/R4: idle host sweep
    for (int i = 0; i < 24; i++) begin
      host_req = 1; host_addr = AW'(i * 1237);
      step(); step(); step();
    end
    chk(core_reads == 0, "R4 no idle core reads", core_reads, 0);

    // R5/R6: prefetch with no consumer, wrap across top of address space
    core_reads = 0;
    do_arm(16'hFFFC);
    core_reads = 0;
    for (int i = 0; i < 20; i++) step();
    chk(fifo_count == DEPTH, "R6 fills to depth", fifo_count, DEPTH);
    chk(core_reads == DEPTH, "R6 stops when full", core_reads, DEPTH);

    // R6/R7: drain and refill
    auto_pop = 1;
    for (int i = 0; i < 40; i++) step();
    chk(exp_pop == AW'(16'hFFFC + 40), "R6 resume after pop", exp_pop, 16'hFFFC + 40);

    // R11: host every 6 cycles while core pops each cycle
    for (int i = 0; i < 240; i++) begin
      if (i % 6 == 0) begin host_req = 1; host_addr = AW'(i * 91 + 5); end
      step();
    end
    chk(exp_pop > AW'(16'hFFFC + 40 + 150), "R11 stream rate", exp_pop, 0);

    // R10: re-arm while active
    auto_pop = 0;
    for (int i = 0; i < 10; i++) step();
    do_arm(16'h0420);
    chk(fifo_count == 0, "R10 queue discarded", fifo_count, 0);
    for (int i = 0; i < 4; i++) step();
    chk(fifo_data == rom_byte(16'h0420), "R10 head at new start", fifo_data, rom_byte(16'h0420));
    auto_pop = 1;
    for (int i = 0; i < 30; i++) step();

    // R9: abort mid-stream
    auto_pop = 0;
    step();
    abort = 1; armed = 0;
    step_keep();
    chk(fifo_count == 0 && fifo_empty, "R9 abort clears", fifo_count, 0);
    core_reads = 0;
    for (int i = 0; i < 12; i++) step();
    chk(core_reads == 0 && fifo_count == 0, "R9 fetch stopped", core_reads, 0);

    // R8: pops on empty
    for (int i = 0; i < 3; i++) begin
      fifo_rd = 1;
      @(posedge clk); #1;
      fifo_rd = 0;
      chk(fifo_count == 0 && fifo_empty, "R8 empty pop ignored", fifo_count, 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule